// File: doc/BRIEF.md
# SPI Mode 0 Byte Slave on an Oversampling System Clock

This block is the target side of a mode 0 serial peripheral link (clock idles low, data captured on the rising edge and changed on the falling edge). It runs entirely on a fast local clock. The serial clock, data-in and active-low select lines are treated as plain data. They are sampled through short flip-flop chains, and the rising and falling serial-clock edges are recovered as single-cycle strobes. Each selected transfer moves one byte in each direction. The incoming byte is assembled MSB first and handed to the local side with a one-cycle valid strobe. Meanwhile a fixed reply byte leaves on the data-out pin, also MSB first.

The reply byte is a parameter, so the block answers every transfer with the same value. A flag output reports whether the most recently completed byte matched a parameterised pattern, which makes a simple indicator, such as a lamp that blinks when a master alternates between two values. The local clock must be many times faster than the serial clock, because recovering each edge takes a few local cycles.

Top module: `spi_byte_slave`

## Requirements
- R1: A synchronous active-high reset sets rx_byte to 0, rx_strobe to 0 and pattern_hit to 0, and sets miso to bit 7 of the reply byte (0 for the default 0x55).
- R2: While select is low, each rising serial-clock edge shifts the sampled mosi level into bit 0 of the shift register. After the eighth rising edge, rx_byte holds the eight bits with the first one received in bit 7.
- R3: rx_strobe is high for exactly one local clock cycle for each completed byte, and rx_byte is valid during that cycle.
- R4: miso carries the reply byte MSB first. The first bit is present before the first rising edge, and each later bit follows a falling edge. Bytes sent back to back inside one selection each carry the full reply.
- R5: Raising select in the middle of a byte discards the partial byte, produces no rx_strobe and restarts bit counting at the first bit of the next selection.
- R6: Serial-clock edges while select is high are ignored. They produce no strobe and do not change rx_byte or the following transfer.
- R7: pattern_hit is 1 exactly when the last completed byte equals the match pattern (0xAA by default). It holds its value until the next byte completes.
- R8: While select is high, miso equals bit 7 of the reply byte.
- R9: rx_strobe is high in the third local clock cycle after the eighth rising serial-clock level is presented at sclk_in: two sampling stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local system clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_in | input | 1 | Serial clock from the master, sampled as data |
| mosi_in | input | 1 | Serial data from the master |
| ssn_in | input | 1 | Select from the master, active low |
| miso | output | 1 | Serial data to the master |
| rx_byte | output | W | Last completed received byte |
| rx_strobe | output | 1 | One-cycle pulse when rx_byte is updated |
| pattern_hit | output | 1 | Last completed byte equals the match pattern |

## Verification
The bench runs several bytes back to back inside one selection. A design that forgets to reload the reply after the eighth bit would send shifted-in master data on the second byte, and one that drops the first bit would return a rotated reply. A partial byte is cut off by deselecting. If the bit counter is not cleared, the next byte is received misaligned, or a stray strobe appears. Serial-clock toggling while deselected is also checked, because a design that shifts while idle would corrupt rx_byte. The strobe latency is measured exactly, and the pattern flag is observed during long idle gaps, so that a flag which decays or follows the wrong byte is reported.

// File: rtl/spi_byte_slave.sv
module spi_byte_slave #(
  parameter int W = 8,
  parameter logic [W-1:0] REPLY = 'h55,
  parameter logic [W-1:0] MATCH = 'hAA
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_in,
  input  logic         mosi_in,
  input  logic         ssn_in,
  output logic         miso,
  output logic [W-1:0] rx_byte,
  output logic         rx_strobe,
  output logic         pattern_hit
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [2:0]    sclk_q;
  logic [1:0]    mosi_q;
  logic [1:0]    ssn_q;
  logic [CW-1:0] bit_cnt;
  logic [W-1:0]  shreg;
  logic          miso_q;

  wire          sclk_rise = (sclk_q[2:1] == 2'b01);
  wire          sclk_fall = (sclk_q[2:1] == 2'b10);
  wire          active    = ~ssn_q[1];
  wire          last_bit  = (bit_cnt == CW'(W - 1));
  wire [W-1:0]  shifted   = {shreg[W-2:0], mosi_q[1]};

  assign miso = miso_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      mosi_q <= '0;
      ssn_q  <= '1;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk_in};
      mosi_q <= {mosi_q[0], mosi_in};
      ssn_q  <= {ssn_q[0], ssn_in};
    end
  end

  always_ff @(posedge clk) begin
    rx_strobe <= 1'b0;
    if (rst) begin
      bit_cnt     <= '0;
      shreg       <= REPLY;
      miso_q      <= REPLY[W-1];
      rx_byte     <= '0;
      pattern_hit <= 1'b0;
    end else if (!active) begin
      bit_cnt <= '0;
      shreg   <= REPLY;
      miso_q  <= REPLY[W-1];
    end else begin
      if (sclk_rise) begin
        if (last_bit) begin
          bit_cnt     <= '0;
          shreg       <= REPLY;
          rx_byte     <= shifted;
          rx_strobe   <= 1'b1;
          pattern_hit <= (shifted == MATCH);
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          shreg   <= shifted;
        end
      end
      if (sclk_fall)
        miso_q <= shreg[W-1];
    end
  end
endmodule

// File: rtl/spi_byte_slave_chk.sv
module spi_byte_slave_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] REPLY = 'h55,
  parameter logic [W-1:0] MATCH = 'hAA,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          miso,
  input logic [W-1:0]  rx_byte,
  input logic          rx_strobe,
  input logic          pattern_hit,
  input logic          active,
  input logic [CW-1:0] bit_cnt
);
  a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |=> !rx_strobe);

  a_r5_count_cleared: assert property (@(posedge clk) disable iff (rst)
    !active |=> (bit_cnt == '0));

  a_r5_strobe_needs_select: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |-> $past(active));

  a_r7_hit_matches_byte: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |-> (pattern_hit == (rx_byte == MATCH)));

  a_r7_hit_held: assert property (@(posedge clk) disable iff (rst)
    !rx_strobe |-> ($stable(pattern_hit) && $stable(rx_byte)));

  a_r8_miso_idle: assert property (@(posedge clk) disable iff (rst)
    !active |=> (miso == REPLY[W-1]));
endmodule

bind spi_byte_slave spi_byte_slave_chk #(
  .W(W), .REPLY(REPLY), .MATCH(MATCH), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .miso(miso), .rx_byte(rx_byte),
  .rx_strobe(rx_strobe), .pattern_hit(pattern_hit),
  .active(active), .bit_cnt(bit_cnt)
);

// File: tb/spi_byte_slave_bench.sv
`timescale 1ns/1ps
module spi_byte_slave_bench;
  localparam int H = 8;
  localparam int NV = 8;
  localparam logic [7:0] TX_VEC [NV] = '{8'hAA, 8'h55, 8'hAA, 8'h55, 8'h00, 8'hFF, 8'h81, 8'h7E};

  logic clk = 0, rst = 1, sclk_in = 0, mosi_in = 0, ssn_in = 1;
  logic miso, rx_strobe, pattern_hit;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0;
  int cyc = 0, strobe_cnt = 0, strobe_cyc = 0, rise_cyc = 0;
  logic [7:0] got;
  logic prev_strobe = 0, long_strobe = 0;

  always #2 clk = ~clk;

  spi_byte_slave u_spi_byte_slave (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .mosi_in(mosi_in), .ssn_in(ssn_in),
    .miso(miso), .rx_byte(rx_byte), .rx_strobe(rx_strobe), .pattern_hit(pattern_hit)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rx_strobe) begin
      strobe_cnt <= strobe_cnt + 1;
      strobe_cyc <= cyc;
      if (prev_strobe) long_strobe <= 1'b1;
    end
    prev_strobe <= rx_strobe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi_in = b[i];
      wait_cyc(H);
      sclk_in = 1'b1;
      r[i] = miso;
      rise_cyc = cyc;
      wait_cyc(H);
      sclk_in = 1'b0;
    end
    wait_cyc(H);
  endtask

  task automatic select(input logic s);
    @(negedge clk);
    ssn_in = ~s;
    wait_cyc(H);
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    wait_cyc(5);
    chk("R1 rx_byte", rx_byte, 0);
    chk("R1 rx_strobe", rx_strobe, 0);
    chk("R1 pattern_hit", pattern_hit, 0);
    chk("R1 miso", miso, 0);
    @(negedge clk); rst = 0;
    wait_cyc(4);
    chk("R8 miso idle", miso, 0);

    select(1);
    for (int v = 0; v < NV; v++) begin
      base = strobe_cnt;
      xfer(TX_VEC[v], got);
      chk("R2 rx_byte", rx_byte, TX_VEC[v]);
      chk("R3 strobe count", strobe_cnt - base, 1);
      chk("R3 single cycle", long_strobe, 0);
      chk("R4 miso byte", got, 8'h55);
      chk("R7 pattern_hit", pattern_hit, TX_VEC[v] == 8'hAA);
      chk("R9 strobe latency", strobe_cyc - rise_cyc, 3);
    end
    select(0);

    select(1);
    xfer(8'hAA, got);
    select(0);
    wait_cyc(60);
    chk("R7 hit held", pattern_hit, 1);
    chk("R7 rx held", rx_byte, 8'hAA);

    base = strobe_cnt;
    mosi_in = 1'b1;
    for (int k = 0; k < 20; k++) begin
      wait_cyc(H); sclk_in = ~sclk_in;
    end
    wait_cyc(H);
    chk("R6 no strobe idle", strobe_cnt - base, 0);
    chk("R6 rx unchanged", rx_byte, 8'hAA);
    select(1);
    xfer(8'h3C, got);
    chk("R6 next byte", rx_byte, 8'h3C);
    chk("R4 reply after idle clocks", got, 8'h55);
    select(0);

    select(1);
    base = strobe_cnt;
    for (int i = 0; i < 3; i++) begin
      mosi_in = 1'b1;
      wait_cyc(H); sclk_in = 1'b1;
      wait_cyc(H); sclk_in = 1'b0;
    end
    wait_cyc(H);
    select(0);
    wait_cyc(4);
    chk("R5 no strobe partial", strobe_cnt - base, 0);
    chk("R8 miso after abort", miso, 0);
    select(1);
    xfer(8'hC3, got);
    chk("R5 realigned byte", rx_byte, 8'hC3);
    chk("R5 reply realigned", got, 8'h55);
    select(0);

    select(1);
    xfer(8'hAA, got);
    select(0);
    chk("R7 hit before reset", pattern_hit, 1);
    @(negedge clk); rst = 1;
    wait_cyc(2);
    chk("R1 hit cleared", pattern_hit, 0);
    chk("R1 rx cleared", rx_byte, 0);
    @(negedge clk); rst = 0;
    wait_cyc(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule